// File: doc/BRIEF.md
# Hall Edge Interval Timer

This block measures how long a single Hall sensor output stays in each state. A motor drive uses the interval to set the stator frequency for the next half electrical cycle. An edge of either polarity ends one interval and starts the next. A free-running timebase counts from 0 to 249 once per prescaled tick. Each edge latches the timebase value. A separate counter records how many times the timebase wrapped between two edges. The interval is then rebuilt from the two latched values and that wrap count. With the default prescaler of 32 on an 8 MHz clock, a tick is 4 µs and a wrap is 1 ms.

Wrap events reach the wrap counter one cycle late, in the same way a serviced interrupt would. An edge can therefore arrive while a wrap is still unfolded. The latched value resolves this case. A small value means the timebase has already restarted, so the wrap belongs to the interval that is ending. A large value means the edge came first, so the wrap belongs to the next interval. When an interval holds more wraps than the wrap counter can represent, the block reports it as too slow instead of giving a wrong value.

Top module: `hall_semiperiod_timer`

## Requirements
- R1: While reset is held and just after it is released, `period_o`, `valid_o`, `rising_o` and `slow_o` are all zero.
- R2: The timebase advances once every PRESCALE clocks. It runs 0 to TB_MOD−1 and then returns to 0, so one wrap spans TB_MOD ticks.
- R3: `hall_i` passes through two synchronizing flops before edge detection. `rising_o` is 1 for a low-to-high edge and 0 for a high-to-low edge.
- R4: The first edge after reset only starts the measurement and gives no `valid_o`.
- R5: When no wrap lies between two edges, the reported interval is the later latched value minus the earlier one.
- R6: When N wraps lie between two edges (1 ≤ N ≤ 2^OVF_W−1), the interval is (TB_MOD − earlier) + later + TB_MOD·(N−1).
- R7: Suppose an edge arrives while a wrap from the previous cycle is still unfolded, and the latched value is below TB_MOD/2. That wrap then counts in the interval now ending and is not counted again in the next one.
- R8: Suppose an edge arrives in the same cycle as a wrap, and the latched value is at or above TB_MOD/2 (it is TB_MOD−1 here). That wrap then stays out of the interval now ending and counts in the next one.
- R9: When more than 2^OVF_W−1 wraps lie between two edges, `slow_o` is 1 and `period_o` is all ones. The wrap counter saturates and does not wrap around. The next interval is measured normally again.
- R10: `valid_o` is a one-cycle pulse three clocks after the `hall_i` change that caused it. `period_o`, `rising_o` and `slow_o` hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_i | input | 1 | Asynchronous Hall sensor level |
| period_o | output | PER_W | Measured interval in timebase ticks |
| valid_o | output | 1 | One-cycle strobe for a new interval |
| rising_o | output | 1 | Polarity of the edge that closed the interval |
| slow_o | output | 1 | Interval exceeded the wrap counter range |

## Verification
The input patterns are chosen so that each one separates a different part of the interval logic:
- Edges a few ticks apart, with no wrap between them, test the plain subtraction.
- Intervals spanning several wraps test the wrap-count formula.
- An edge placed exactly in the wrap cycle tests the case where the wrap is deferred to the next interval.
- An edge placed in the first cycle after a wrap tests the case where the wrap is folded into the interval now ending.
- An interval that follows the folded case shows whether that wrap was counted twice.
- Intervals with exactly seven and eight wraps bracket the saturation limit.
- A short interval after a saturated one shows that measurement recovers.

The bench derives every expected value from the total tick count at the cycle the edge is recognised. It does not use the formula the design applies.

// File: rtl/hall_tmr_pkg.sv
package hall_tmr_pkg;

  // Rebuild an interval from the two latched timebase values and the wrap count.
  function automatic int unsigned span_ticks(int unsigned c_open, int unsigned c_close,
                                             int unsigned wraps, int unsigned modv);
    if (wraps == 0) return c_close - c_open;
    return (modv - c_open) + c_close + modv * (wraps - 1);
  endfunction

  // Decide whether an unfolded wrap belongs to the interval that is closing.
  function automatic bit fold_now(bit pend, int unsigned cap, int unsigned half);
    return pend && (cap < half);
  endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic edge_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level_o = s2;
  assign edge_o  = s2 ^ s3;
endmodule

// File: rtl/hall_timebase.sv
module hall_timebase #(
  parameter int PRESCALE = 32,
  parameter int TB_MOD   = 250,
  parameter int TB_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TB_W-1:0] cnt_o,
  output logic            roll_o,
  output logic            roll_q_o
);
  logic tick;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst)                          pre <= '0;
        else if (pre == PW'(PRESCALE-1))  pre <= '0;
        else                              pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(PRESCALE-1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign roll_o = tick && (cnt_o == TB_W'(TB_MOD-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      roll_q_o <= 1'b0;
    end else begin
      roll_q_o <= roll_o;
      if (roll_o)     cnt_o <= '0;
      else if (tick)  cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/hall_wrap_track.sv
module hall_wrap_track #(
  parameter int OVF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic             roll_q_i,
  input  logic             fold_i,
  output logic [OVF_W-1:0] ovf_o,
  output logic             slow_o,
  output logic             armed_o
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o   <= '0;
      slow_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (edge_i) begin
      armed_o <= 1'b1;
      slow_o  <= 1'b0;
      // An unfolded wrap that was not taken now opens the next interval.
      ovf_o   <= (roll_q_i && !fold_i) ? OVF_W'(1) : '0;
    end else if (roll_q_i) begin
      if (ovf_o == OVF_MAX) slow_o <= 1'b1;
      else                  ovf_o  <= ovf_o + 1'b1;
    end
  end
endmodule

// File: rtl/hall_semiperiod_timer.sv
module hall_semiperiod_timer
  import hall_tmr_pkg::*;
#(
  parameter int PRESCALE = 32,
  parameter int TB_MOD   = 250,
  parameter int OVF_W    = 3,
  localparam int TB_W    = $clog2(TB_MOD),
  localparam int PER_W   = $clog2(TB_MOD * (2 ** OVF_W))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hall_i,
  output logic [PER_W-1:0] period_o,
  output logic             valid_o,
  output logic             rising_o,
  output logic             slow_o
);
  localparam int unsigned HALF = TB_MOD / 2;
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic            hall_lvl, edge_evt;
  logic [TB_W-1:0] tb_cnt, prev_cap;
  logic            roll_evt, roll_pend_q, fold_evt;
  logic [OVF_W-1:0] ovf_cnt;
  logic            slow_flag, armed, slow_now;
  int unsigned     wraps_eff;

  hall_sync u_sync (
    .clk(clk), .rst(rst), .din(hall_i), .level_o(hall_lvl), .edge_o(edge_evt)
  );

  hall_timebase #(.PRESCALE(PRESCALE), .TB_MOD(TB_MOD), .TB_W(TB_W)) u_tb (
    .clk(clk), .rst(rst), .cnt_o(tb_cnt), .roll_o(roll_evt), .roll_q_o(roll_pend_q)
  );

  assign fold_evt = fold_now(roll_evt || roll_pend_q, 32'(tb_cnt), HALF);

  hall_wrap_track #(.OVF_W(OVF_W)) u_wrap (
    .clk(clk), .rst(rst), .edge_i(edge_evt), .roll_q_i(roll_pend_q), .fold_i(fold_evt),
    .ovf_o(ovf_cnt), .slow_o(slow_flag), .armed_o(armed)
  );

  assign wraps_eff = 32'(ovf_cnt) + 32'(fold_evt);
  assign slow_now  = slow_flag || (fold_evt && ovf_cnt == OVF_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cap <= '0;
      period_o <= '0;
      valid_o  <= 1'b0;
      rising_o <= 1'b0;
      slow_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (edge_evt) begin
        prev_cap <= tb_cnt;
        if (armed) begin
          valid_o  <= 1'b1;
          rising_o <= hall_lvl;
          slow_o   <= slow_now;
          period_o <= slow_now ? '1
                    : PER_W'(span_ticks(32'(prev_cap), 32'(tb_cnt), wraps_eff, TB_MOD));
        end
      end
    end
  end
endmodule

// File: rtl/hall_semiperiod_checker.sv
module hall_semiperiod_checker #(
  parameter int TB_MOD = 250,
  parameter int OVF_W  = 3,
  parameter int TB_W   = 8,
  parameter int PER_W  = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [PER_W-1:0] period_o,
  input logic             valid_o,
  input logic             slow_o,
  input logic             edge_evt,
  input logic             armed,
  input logic             roll_evt,
  input logic [TB_W-1:0]  tb_cnt
);
  localparam int unsigned PER_LIM = TB_MOD * (2 ** OVF_W);

  assert_tb_range_R2: assert property (@(posedge clk) disable iff (rst)
    32'(tb_cnt) < TB_MOD);

  assert_tb_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    roll_evt |=> tb_cnt == '0);

  assert_arm_only_R4: assert property (@(posedge clk) disable iff (rst)
    (edge_evt && !armed) |=> !valid_o);

  assert_valid_after_edge_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(edge_evt));

  assert_slow_saturates_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_o && slow_o) |-> period_o == {PER_W{1'b1}});

  assert_period_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !slow_o) |-> 32'(period_o) < PER_LIM);
endmodule

bind hall_semiperiod_timer hall_semiperiod_checker #(
  .TB_MOD(TB_MOD), .OVF_W(OVF_W), .TB_W(TB_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst(rst), .period_o(period_o), .valid_o(valid_o), .slow_o(slow_o),
  .edge_evt(edge_evt), .armed(armed), .roll_evt(roll_evt), .tb_cnt(tb_cnt)
);

// File: tb/sim_hall_semiperiod_timer.sv
module sim_hall_semiperiod_timer;
  localparam int CLK_PERIOD = 10;
  localparam int P      = 4;
  localparam int MODV   = 250;
  localparam int OW     = 3;
  localparam int PW     = $clog2(MODV * (2 ** OW));
  localparam int LAT    = 2;          // cycles from drive to edge recognition
  localparam int WRAPMX = 2 ** OW - 1;

  typedef struct {
    int    per;
    bit    rise;
    bit    slow;
    int    cyc;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hall = 1'b0;
  logic [PW-1:0] period;
  logic          valid, rising, slow;

  int   bcyc = 0;
  int   n_run = 0, n_fail = 0;
  exp_t sb[$];
  bit   b_armed = 1'b0;
  int   last_t = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) bcyc <= 0;
    else     bcyc <= bcyc + 1;
  end

  hall_semiperiod_timer #(.PRESCALE(P), .TB_MOD(MODV), .OVF_W(OW)) u0 (
    .clk(clk), .rst(rst), .hall_i(hall),
    .period_o(period), .valid_o(valid), .rising_o(rising), .slow_o(slow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Toggle the Hall input at bench cycle k and predict the resulting interval.
  task automatic toggle_at(input int k, input string req);
    int t_now, wraps;
    exp_t e;
    while (bcyc < k) @(negedge clk);
    hall = ~hall;
    t_now = (k + LAT) / P;
    if (!b_armed) begin
      b_armed = 1'b1;
    end else begin
      wraps  = t_now / MODV - last_t / MODV;
      e.slow = (wraps > WRAPMX);
      e.per  = e.slow ? (2 ** PW - 1) : (t_now - last_t);
      e.rise = hall;
      e.cyc  = k + LAT + 1;
      e.req  = req;
      sb.push_back(e);
    end
    last_t = t_now;
  endtask

  // Monitor: pop the scoreboard on every strobe.
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(period) == e.per, {e.req, " period"}, int'(period), e.per);
        check(rising == e.rise, "R3 polarity", int'(rising), int'(e.rise));
        check(slow == e.slow, "R9 slow flag", int'(slow), int'(e.slow));
        check(bcyc == e.cyc, "R10 strobe cycle", bcyc, e.cyc);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(period == '0, "R1 period", int'(period), 0);
        check(!valid, "R1 valid", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rising, "R1 rising", int'(rising), 0);
        check(!slow, "R1 slow", int'(slow), 0);
        toggle_at(100,   "R4");        // arms only
        toggle_at(140,   "R5");        // 10 ticks, no wrap
        toggle_at(152,   "R5");        // 3 ticks, short interval
        toggle_at(2700,  "R6");        // two wraps
        toggle_at(2997,  "R8");        // recognised in the wrap cycle, latch 249
        toggle_at(3500,  "R8");        // deferred wrap counted here
        toggle_at(3998,  "R7");        // recognised right after wrap, latch 0
        toggle_at(4100,  "R7");        // folded wrap not counted twice
        toggle_at(13100, "R9");        // nine wraps, saturates
        toggle_at(13200, "R9");        // recovery
        toggle_at(20798, "R6");        // seven wraps, at limit
        toggle_at(28398, "R9");        // eight wraps, saturates
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R10 all strobes seen", sb.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog R10", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule